// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit-Slip

This block turns a serial bit stream into 8-bit parallel words. It takes the stream from one of two serial inputs, so a loop-back path can be run through the second input. It packs the bits so that the earliest bit lands in the lowest output bit. Each finished word is written to an output register, and a strobe marks it for one clock. The capture rate is chosen at run time. In one setting the block takes one bit per rising clock edge. In the other it takes two bits per clock period: one on the falling edge and one on the rising edge.

Word framing is adjusted with a slip input, which is asynchronous to the clock. The block first synchronizes it. When it then stays high for two clocks in a row, the block throws away exactly one incoming bit, and every later word boundary moves one bit further along the stream. A gating enable is sampled only on the falling edge. This keeps a change of enable from ever producing a partial capture slot. A master reset clears the whole datapath at once, with no clock needed.

Top module: `serial_word_deser`

## Requirements
- R1: Serial bits fill the word in arrival order: the first accepted bit of a word appears on word_out[0], and the eighth on word_out[7].
- R2: With lane_sel low the stream is taken from ser_a, and with lane_sel high from ser_b. The input that is not selected has no effect on the word.
- R3: With rate_sel high, one bit is taken at each rising edge. A full word needs eight rising edges.
- R4: With rate_sel low, two bits are taken per clock period. The bit present at the falling edge comes before the bit present at the following rising edge, and a full word needs four periods.
- R5: sync_in goes through two synchronizing flops. It must then be seen high for two consecutive cycles before exactly one bit is dropped. The dropped bit is the one due at the fourth rising edge after the first rising edge that samples sync_in high. In the dual rate that is the falling-edge bit of that period. A one-cycle pulse on sync_in drops nothing.
- R6: Holding sync_in high for many cycles drops only one bit. A further drop needs sync_in to go low and then high again for at least two cycles.
- R7: Raising rst clears word_out, word_valid, the bit count and the partial word immediately, with no clock edge.
- R8: clk_en is sampled on the falling edge. In a period where the sampled enable is low, no bit is taken and the partial word and the bit count hold their values.
- R9: word_valid is high for exactly one clock, in the same cycle that word_out takes the new word. word_out does not change between strobes.
- R10: After reset, word_out reads zero and word_valid stays low until eight new bits have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used in the dual rate |
| rst | input | 1 | Asynchronous master reset, active high |
| ser_a | input | 1 | Serial data input, lane 0 |
| ser_b | input | 1 | Serial data input, lane 1 (loop-back) |
| lane_sel | input | 1 | 0 selects ser_a, 1 selects ser_b |
| rate_sel | input | 1 | 1: one bit per period; 0: two bits per period |
| sync_in | input | 1 | Asynchronous request to slip the word framing by one bit |
| clk_en | input | 1 | Capture enable, sampled on the falling edge |
| word_out | output | 8 | Last completed parallel word |
| word_valid | output | 1 | One-cycle strobe marking a newly loaded word |

## Verification
A bit count that is off by one puts every later strobe one clock early or late. The very next word then shows up rotated, within eight bit times, and the rotation never corrects itself. A slip qualifier that misfires is seen on the first strobe after the sync pulse. A held sync input that fires twice makes the following word differ by one more rotation. A swapped edge order in the dual rate swaps adjacent bit pairs in the first word. A leaky enable shows up as extra bits and an early strobe within one word.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic {
        RATE_DUAL   = 1'b0,
        RATE_SINGLE = 1'b1
    } rate_e;

    // partial word being assembled
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } acc_t;

    // result of absorbing one bit
    typedef struct packed {
        acc_t              acc;
        logic              done;
        logic [WORD_W-1:0] word;
    } step_t;

    // new bit enters at the top, so the earliest bit ends at index 0
    function automatic step_t push_bit(acc_t a, logic b);
        step_t r;
        r.acc.shreg = {b, a.shreg[WORD_W-1:1]};
        r.done      = (a.cnt == CNT_W'(WORD_W-1));
        r.word      = r.acc.shreg;
        r.acc.cnt   = r.done ? '0 : a.cnt + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/deser_frontend.sv
module deser_frontend (
    input  logic clk,
    input  logic rst,
    input  logic ser_a,
    input  logic ser_b,
    input  logic lane_sel,
    input  logic clk_en,
    output logic ser_bit,
    output logic fall_bit,
    output logic en_q
);
    // lane mux ahead of both capture edges
    assign ser_bit = lane_sel ? ser_b : ser_a;

    // falling-edge capture: first bit of a dual-rate period, and the
    // enable, updated mid-period so a rising-edge slot is never cut short
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            fall_bit <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            fall_bit <= ser_bit;
            en_q     <= clk_en;
        end
    end
endmodule

// File: rtl/deser_slip_ctl.sv
module deser_slip_ctl #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic consume,
    output logic slip_pend
);
    logic [STAGES-1:0] chain;
    logic              sync_s;
    logic              s_prev;
    logic              used;
    logic              fire;

    assign sync_s = chain[STAGES-1];
    assign fire   = sync_s & s_prev & ~used;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain     <= '0;
            s_prev    <= 1'b0;
            used      <= 1'b0;
            slip_pend <= 1'b0;
        end else begin
            chain     <= {chain[STAGES-2:0], sync_in};
            s_prev    <= sync_s;
            used      <= sync_s & (used | fire);
            slip_pend <= fire | (slip_pend & ~consume);
        end
    end

    // R5: a slip is only armed after two synchronized high samples
    a_r5_needs_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(slip_pend) |-> ($past(sync_s) && $past(s_prev)));

    // R6: once consumed, a pending slip does not re-arm from the same hold
    a_r6_one_per_hold: assert property (@(posedge clk) disable iff (rst)
        (slip_pend && consume) |=> !slip_pend);
endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_a,
    input  logic       ser_b,
    input  logic       lane_sel,
    input  logic       rate_sel,
    input  logic       sync_in,
    input  logic       clk_en,
    output logic [7:0] word_out,
    output logic       word_valid
);
    import deser_pkg::*;

    logic  ser_bit, fall_bit, en_q, slip_pend;
    acc_t  acc_q, acc_m, acc_d;
    step_t st0, st1;
    logic  use0, use1, b0, b1;

    deser_frontend u_fe (
        .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b),
        .lane_sel(lane_sel), .clk_en(clk_en),
        .ser_bit(ser_bit), .fall_bit(fall_bit), .en_q(en_q)
    );

    deser_slip_ctl #(.STAGES(SYNC_STAGES)) u_slip (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .consume(en_q), .slip_pend(slip_pend)
    );

    // slot 0 = falling-edge bit (dual only), slot 1 = rising-edge bit;
    // a pending slip removes the earliest slot of the period
    always_comb begin
        b0 = fall_bit;
        b1 = ser_bit;
        if (rate_e'(rate_sel) == RATE_SINGLE) begin
            use0 = 1'b0;
            use1 = ~slip_pend;
        end else begin
            use0 = ~slip_pend;
            use1 = 1'b1;
        end
        st0   = push_bit(acc_q, b0);
        acc_m = use0 ? st0.acc : acc_q;
        st1   = push_bit(acc_m, b1);
        acc_d = use1 ? st1.acc : acc_m;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            acc_q      <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (en_q) begin
                acc_q <= acc_d;
                if (use1 && st1.done) begin
                    word_out   <= st1.word;
                    word_valid <= 1'b1;
                end else if (use0 && st0.done) begin
                    word_out   <= st0.word;
                    word_valid <= 1'b1;
                end
            end
        end
    end

    // R9: strobe lasts one clock (words are at least four periods apart)
    a_r9_strobe_once: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R9: the output word only moves together with the strobe
    a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));

    // R8: a period with the sampled enable low leaves the partial word alone
    a_r8_gate_holds: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(acc_q));
endmodule

// File: tb/serial_word_deser_test.sv
module serial_word_deser_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_a = 1'b0, ser_b = 1'b1;
    logic       lane_sel = 1'b0, rate_sel = 1'b1;
    logic       sync_in = 1'b0, clk_en = 1'b0;
    logic [7:0] word_out;
    logic       word_valid;

    int errors = 0;
    int checks = 0;

    serial_word_deser uut (
        .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b),
        .lane_sel(lane_sel), .rate_sel(rate_sel), .sync_in(sync_in),
        .clk_en(clk_en), .word_out(word_out), .word_valid(word_valid)
    );

    always #2 clk = ~clk;   // 250 MHz

    // {rate_sel, lane_sel, word}
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 1'b0, 8'hA5}, {1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b0, 8'h96}, {1'b0, 1'b1, 8'hE1},
        {1'b1, 1'b0, 8'h01}, {1'b0, 1'b1, 8'h80},
        {1'b1, 1'b1, 8'h7E}, {1'b0, 1'b0, 8'h5A}
    };
    localparam logic [63:0] PAT = 64'hD3A1_5C7E_9B24_F068;

    task automatic chk(input bit ok, input string req,
                       input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drv(input logic b);
        if (lane_sel) begin ser_b = b; ser_a = ~b; end
        else          begin ser_a = b; ser_b = ~b; end
    endtask

    // called at rising edge + 1 ns; returns at next rising edge + 1 ns
    task automatic cyc(input logic en, input logic bf, input logic br, input logic sy);
        clk_en  = en;
        sync_in = sy;
        drv(bf);
        #2;
        drv(br);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] acc;
        logic [7:0] exp_word;
        int         n;

        @(posedge clk); #1;
        // R7 R10: reset state
        chk(word_out == 8'h00, "R7 reset word", {1'b0, word_out}, 9'h0);
        chk(word_valid == 1'b0, "R10 reset strobe", {8'h0, word_valid}, 9'h0);
        do_reset();

        // table walk: R1 R2 R3 R4 R9
        foreach (VEC[v]) begin
            logic [7:0] w;
            bit early;
            w        = VEC[v][7:0];
            rate_sel = VEC[v][9];
            lane_sel = VEC[v][8];
            early    = 1'b0;
            if (rate_sel) begin
                for (int j = 0; j < 8; j++) begin
                    cyc(1'b1, w[j], w[j], 1'b0);
                    if (j < 7 && word_valid) early = 1'b1;
                end
            end else begin
                for (int j = 0; j < 4; j++) begin
                    cyc(1'b1, w[2*j], w[2*j+1], 1'b0);
                    if (j < 3 && word_valid) early = 1'b1;
                end
            end
            chk(!early, rate_sel ? "R3 no early strobe" : "R4 no early strobe",
                {8'h0, early}, 9'h0);
            chk(word_valid == 1'b1, "R9 strobe on last bit", {8'h0, word_valid}, 9'h1);
            chk(word_out == w, lane_sel ? "R1 R2 word via ser_b" : "R1 R2 word via ser_a",
                {1'b0, word_out}, {1'b0, w});
        end
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(word_valid == 1'b0, "R9 strobe one clock", {8'h0, word_valid}, 9'h0);
        chk(word_out == 8'h5A, "R9 word held", {1'b0, word_out}, 9'h05A);

        // R8: gated periods take no bits
        do_reset();
        rate_sel = 1'b1; lane_sel = 1'b0;
        begin
            logic [7:0] w;
            bit seen;
            w = 8'hC6; seen = 1'b0;
            for (int j = 0; j < 4; j++) cyc(1'b1, w[j], w[j], 1'b0);
            for (int j = 0; j < 3; j++) begin
                cyc(1'b0, 1'b1, 1'b1, 1'b0);
                if (word_valid) seen = 1'b1;
            end
            for (int j = 4; j < 8; j++) begin
                cyc(1'b1, w[j], w[j], 1'b0);
                if (j < 7 && word_valid) seen = 1'b1;
            end
            chk(!seen, "R8 no strobe from gated bits", {8'h0, seen}, 9'h0);
            chk(word_valid == 1'b1, "R8 strobe after 8 enabled bits", {8'h0, word_valid}, 9'h1);
            chk(word_out == w, "R8 gated word", {1'b0, word_out}, {1'b0, w});
        end

        // R7: asynchronous clear, no edge in between
        rst = 1'b1;
        #0.5;
        chk(word_out == 8'h00, "R7 async clear word", {1'b0, word_out}, 9'h0);
        chk(word_valid == 1'b0, "R7 async clear strobe", {8'h0, word_valid}, 9'h0);
        @(posedge clk); #1;
        rst = 1'b0;

        // R5 R6 R10: slip sequence checked against a bit-level model
        rate_sel = 1'b1; lane_sel = 1'b0;
        acc = '0; exp_word = '0; n = 0;
        for (int c = 0; c < 80; c++) begin
            logic b, sy, ev;
            bit drop;
            b    = PAT[c % 64];
            sy   = ((c >= 2 && c <= 21) || c == 30 || (c >= 40 && c <= 42));
            drop = (c == 6 || c == 44);     // fourth edge after first high sample
            cyc(1'b1, b, b, sy);
            ev = 1'b0;
            if (!drop) begin
                acc = {b, acc[7:1]};
                n++;
                if (n == 8) begin n = 0; exp_word = acc; ev = 1'b1; end
            end
            chk(word_valid == ev, (c < 8) ? "R10 strobe after reset" :
                                  (c < 30) ? "R5 strobe timing" : "R6 strobe timing",
                {8'h0, word_valid}, {8'h0, ev});
            chk(word_out == exp_word, (c < 8) ? "R10 word after reset" :
                                      (c < 30) ? "R5 slipped word" : "R6 slipped word",
                {1'b0, word_out}, {1'b0, exp_word});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule